// File: doc/BRIEF.md
# Receive Byte Queue with Character Timeout

This block sits between a serial receiver and the host-side register file of a 16550-style UART. It holds received bytes in a 16-entry first-in first-out store, or in a single holding byte when queueing is turned off. It decodes writes to the queue control register and tells the interrupt logic when the fill reaches the selected trigger level or when data has stayed unread for too long. The receiver presents one byte, or a line break, per strobe. The host pops the oldest byte with a read strobe and sees that byte combinationally on `rd_data` in the same cycle.

The character timeout counts down four character times. A character time is given as a count of clock cycles on `char_ticks`, which is worked out elsewhere from the baud divisor and the frame format. The countdown restarts on every accepted byte, and on every read that leaves data behind. It does not run when queueing is off.

Top module: `rx_byte_queue`

## Requirements
- R1: While reset is held and just after it, the fill count is 0, `rd_data` is 0x00, every flag is low, `ctl_state` is 0x00 (holding mode) and `tx_flush` is low.
- R2: With queueing on (`ctl_state[0]`=1), up to 16 bytes are returned in arrival order across pointer wrap. `rx_count` gives the fill and `rd_data` shows the oldest byte.
- R3: `ctl_state[7:6]` selects the trigger level: 00 is 1 byte, 01 is 4, 10 is 8 and 11 is 14. With queueing on, `trig_hit` is high while the fill is at least the level. In holding mode it follows `data_ready`.
- R4: A control write whose value differs from `ctl_state` stores only bits 7:6, 3 and 0 (mask 0xC9). If bit 1 is set, the write empties the queue and clears `data_ready`, `break_flag`, `overrun_flag`, the countdown and `timeout_flag`. If bit 2 is set, `tx_flush` pulses for one cycle. A change of bit 0 acts as if bits 1 and 2 were both set. A write equal to `ctl_state` has no effect.
- R5: With queueing on, `timeout_flag` rises exactly 4×`char_ticks` cycles after the last restart if data is still queued. A restart is an accepted byte, or a read that leaves data behind. Any read clears the flag, and an empty queue never raises it.
- R6: With queueing on, an accepted byte sets `data_ready`. A read that empties the queue clears `data_ready` and `break_flag`.
- R7: In holding mode a byte replaces the holding byte and sets `data_ready`. A read clears `data_ready` and `break_flag`. A byte that arrives while `data_ready` is set and no read is made sets `overrun_flag`.
- R8: A break strobe is taken as a received 0x00 byte and also sets `break_flag` and `data_ready`.
- R9: A read from an empty queue returns 0x00 and leaves the fill at 0.
- R10: A byte that arrives while 16 bytes are queued is dropped, even if a read is made in the same cycle, and `overrun_flag` is set. Only a receive flush clears that flag.
- R11: In a cycle with a control write, the receive and read strobes are ignored.
- R12: With queueing on, a byte arriving in the same cycle as a read is stored while the oldest byte is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_ticks | input | 12 | One character time in clock cycles |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line break received strobe |
| ctl_wr | input | 1 | Queue control register write strobe |
| ctl_wdata | input | 8 | Queue control write value |
| rd_req | input | 1 | Host read of the receive buffer |
| rd_data | output | 8 | Byte returned by the read |
| rx_count | output | 5 | Current fill |
| data_ready | output | 1 | Received data available |
| break_flag | output | 1 | Break seen |
| overrun_flag | output | 1 | Byte lost |
| trig_hit | output | 1 | Fill at or above trigger level |
| timeout_flag | output | 1 | Character timeout pending |
| ctl_state | output | 8 | Stored control bits |
| tx_flush | output | 1 | One-cycle transmit queue flush request |

## Verification
The hardest state to reach is a countdown that expires at the same edge as another event. Examples are a read that empties the queue exactly at expiry, or a flush while the countdown still has cycles left. A small `char_ticks` keeps the window at twelve cycles, and the stimulus places reads and flushes at chosen offsets inside it. The full-queue drop is reached by sixteen back-to-back bytes and then a seventeenth with no read. Each trigger level is swept by a byte-at-a-time fill, so the cycle where `trig_hit` turns on is compared against the model on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // stored control bits: trigger select, dma-style select, queue enable
  localparam byte_t CTL_KEEP = 8'hC9;
  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_RXF_BIT = 1;
  localparam int unsigned CTL_TXF_BIT = 2;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_NEAR = 2'b11
  } trig_sel_e;

  // trigger level scaled to the depth: 1, 4, 8, 14 at depth 16
  function automatic int unsigned trig_level(trig_sel_e sel, int unsigned depth);
    case (sel)
      TRIG_ONE:  return 1;
      TRIG_QTR:  return depth / 4;
      TRIG_HALF: return depth / 2;
      default:   return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl
  import rxq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  byte_t wdata,
  output byte_t ctl_q,
  output logic  rx_flush,
  output logic  tx_flush_q
);
  byte_t eff;
  byte_t ctl_d;
  logic  apply;
  logic  tx_flush_d;

  always_comb begin
    eff   = wdata;
    apply = wr && (wdata != ctl_q);
    if (wdata[CTL_EN_BIT] != ctl_q[CTL_EN_BIT]) begin
      eff[CTL_RXF_BIT] = 1'b1;
      eff[CTL_TXF_BIT] = 1'b1;
    end
    rx_flush   = apply && eff[CTL_RXF_BIT];
    tx_flush_d = apply && eff[CTL_TXF_BIT];
    ctl_d      = apply ? (eff & CTL_KEEP) : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      tx_flush_q <= 1'b0;
    end else begin
      ctl_q      <= ctl_d;
      tx_flush_q <= tx_flush_d;
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          flush,
  input  logic          push,
  input  byte_t         push_data,
  input  logic          pop,
  output byte_t         head_data,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] fill_next,
  output logic          full
);
  byte_t         mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (fill == CW'(DEPTH));
  assign push_ok   = push && fifo_en && !full && !flush;
  assign pop_ok    = pop && fifo_en && (fill != '0) && !flush;
  assign head_data = (fill != '0) ? mem_q[rd_ptr_q] : '0;

  always_comb begin
    wr_ptr_d  = wr_ptr_q;
    rd_ptr_d  = rd_ptr_q;
    fill_next = fill;
    if (flush) begin
      wr_ptr_d  = '0;
      rd_ptr_d  = '0;
      fill_next = '0;
    end else begin
      if (push_ok) wr_ptr_d = bump(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = bump(rd_ptr_q);
      fill_next = fill + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill     <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill     <= fill_next;
    end
  end

  // storage array: written only under its enable, no reset needed
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data;
  end
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter  int unsigned TICK_W = 12,
  localparam int unsigned TW     = TICK_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cancel,
  input  logic              restart,
  input  logic              clear_flag,
  input  logic              nonempty,
  input  logic [TICK_W-1:0] char_ticks,
  output logic              flag_q
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          expire;
  logic          flag_d;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (cancel) begin
      cnt_d = '0;
    end else if (enable) begin
      if (restart) begin
        cnt_d = {char_ticks, 2'b00};
      end else if (cnt_q != '0) begin
        cnt_d  = cnt_q - 1'b1;
        expire = (cnt_q == TW'(1));
      end
    end
    if (cancel || clear_flag)   flag_d = 1'b0;
    else if (expire && nonempty) flag_d = 1'b1;
    else                         flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter  int unsigned DEPTH  = 16,
  parameter  int unsigned TICK_W = 12,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] char_ticks,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_break,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              rd_req,
  output logic [7:0]        rd_data,
  output logic [CW-1:0]     rx_count,
  output logic              data_ready,
  output logic              break_flag,
  output logic              overrun_flag,
  output logic              trig_hit,
  output logic              timeout_flag,
  output logic [7:0]        ctl_state,
  output logic              tx_flush
);
  logic          rx_flush;
  logic          fifo_en;
  logic          rx_any, rd_any;
  byte_t         byte_in, head_data;
  byte_t         hold_q, hold_d;
  logic [CW-1:0] fill_next;
  logic          full;
  logic          restart;
  logic          dr_d, brk_d, ovr_d;
  logic [CW-1:0] level;

  rxq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .ctl_q(ctl_state), .rx_flush(rx_flush), .tx_flush_q(tx_flush)
  );

  assign fifo_en = ctl_state[CTL_EN_BIT];
  assign rx_any  = (rx_valid || rx_break) && !ctl_wr;
  assign rd_any  = rd_req && !ctl_wr;
  assign byte_in = rx_break ? '0 : rx_data;

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(rx_flush),
    .push(rx_any), .push_data(byte_in), .pop(rd_any),
    .head_data(head_data), .fill(rx_count), .fill_next(fill_next), .full(full)
  );

  assign restart = fifo_en && (rx_any || (rd_any && fill_next != '0));

  rxq_timer #(.TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(fifo_en), .cancel(rx_flush),
    .restart(restart), .clear_flag(rd_any), .nonempty(fill_next != '0),
    .char_ticks(char_ticks), .flag_q(timeout_flag)
  );

  always_comb begin
    dr_d   = data_ready;
    brk_d  = break_flag;
    ovr_d  = overrun_flag;
    hold_d = hold_q;
    if (rx_flush) begin
      dr_d  = 1'b0;
      brk_d = 1'b0;
      ovr_d = 1'b0;
    end else begin
      if (rd_any && (!fifo_en || fill_next == '0)) begin
        dr_d  = 1'b0;
        brk_d = 1'b0;
      end
      if (rx_any) begin
        dr_d = 1'b1;
        if (rx_break) brk_d = 1'b1;
        if (fifo_en ? full : (data_ready && !rd_any)) ovr_d = 1'b1;
        if (!fifo_en) hold_d = byte_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_ready   <= 1'b0;
      break_flag   <= 1'b0;
      overrun_flag <= 1'b0;
      hold_q       <= '0;
    end else begin
      data_ready   <= dr_d;
      break_flag   <= brk_d;
      overrun_flag <= ovr_d;
      hold_q       <= hold_d;
    end
  end

  always_comb begin
    level = CW'(trig_level(trig_sel_e'(ctl_state[7:6]), DEPTH));
  end

  assign trig_hit = fifo_en ? (rx_count >= level) : data_ready;
  assign rd_data  = fifo_en ? head_data : hold_q;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          ctl_wr,
  input logic [7:0]    ctl_wdata,
  input logic          rd_req,
  input logic [7:0]    rd_data,
  input logic [CW-1:0] rx_count,
  input logic          data_ready,
  input logic          overrun_flag,
  input logic          timeout_flag,
  input logic [7:0]    ctl_state
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  a_r4_kept_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state & 8'h36) == 8'h00);

  a_r4_same_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata == ctl_state) |=> $stable(ctl_state));

  a_r4_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata != ctl_state &&
     (ctl_wdata[1] || ctl_wdata[0] != ctl_state[0]))
    |=> (rx_count == '0 && !timeout_flag && !data_ready && !overrun_flag));

  a_r5_timeout_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> rx_count != '0);

  a_r6_ready_tracks_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_state[0] |-> (data_ready == (rx_count != '0)));

  a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state[0] && rx_count == '0 && rd_req) |-> rd_data == 8'h00);

  a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state[0] && rx_count == CW'(DEPTH) && (rx_valid || rx_break)
     && !rd_req && !ctl_wr) |=> (rx_count == CW'(DEPTH) && overrun_flag));

  a_r11_ctl_blocks_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata == ctl_state) |=> $stable(rx_count));
endmodule

bind rx_byte_queue rxq_checker #(.DEPTH(DEPTH)) u_rxq_checker (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
  .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rd_req(rd_req), .rd_data(rd_data),
  .rx_count(rx_count), .data_ready(data_ready), .overrun_flag(overrun_flag),
  .timeout_flag(timeout_flag), .ctl_state(ctl_state)
);

// File: tb/rx_byte_queue_test.sv
`timescale 1ns/1ps
module rx_byte_queue_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] char_ticks;
  logic        rx_valid, rx_break, ctl_wr, rd_req;
  logic [7:0]  rx_data, ctl_wdata;
  logic [7:0]  rd_data, ctl_state;
  logic [4:0]  rx_count;
  logic        data_ready, break_flag, overrun_flag, trig_hit, timeout_flag, tx_flush;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string ph  = "R1 reset";

  always #2.5 clk = ~clk;

  rx_byte_queue uut (
    .clk(clk), .rst_n(rst_n), .char_ticks(char_ticks),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rd_req(rd_req),
    .rd_data(rd_data), .rx_count(rx_count), .data_ready(data_ready),
    .break_flag(break_flag), .overrun_flag(overrun_flag), .trig_hit(trig_hit),
    .timeout_flag(timeout_flag), .ctl_state(ctl_state), .tx_flush(tx_flush)
  );

  // behavioural reference model
  byte unsigned q[$];
  int   m_tmr  = 0;
  bit   m_dr   = 0, m_brk = 0, m_ovr = 0, m_to = 0, m_tx = 0;
  bit [7:0] m_ctl  = 0;
  bit [7:0] m_hold = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_tmr = 0; m_dr = 0; m_brk = 0; m_ovr = 0; m_to = 0;
      m_tx = 0; m_ctl = 0; m_hold = 0;
    end else begin
      bit rxin;
      bit [7:0] b;
      rxin = rx_valid || rx_break;
      b    = rx_break ? 8'h00 : rx_data;
      m_tx = 0;
      if (ctl_wr) begin
        if (ctl_wdata != m_ctl) begin
          bit [7:0] v;
          v = ctl_wdata;
          if (v[0] != m_ctl[0]) v = v | 8'h06;
          if (v[1]) begin
            q.delete(); m_dr = 0; m_brk = 0; m_ovr = 0; m_to = 0; m_tmr = 0;
          end
          if (v[2]) m_tx = 1;
          m_ctl = v & 8'hC9;
        end
      end else if (m_ctl[0]) begin
        int n0;
        bit restart;
        n0 = q.size();
        restart = 0;
        if (rd_req) begin
          if (q.size() > 0) void'(q.pop_front());
          m_to = 0;
          if (q.size() == 0) begin m_dr = 0; m_brk = 0; end
          else restart = 1;
        end
        if (rxin) begin
          if (n0 < 16) q.push_back(b); else m_ovr = 1;
          m_dr = 1;
          if (rx_break) m_brk = 1;
          restart = 1;
        end
        if (restart) m_tmr = 4 * int'(char_ticks);
        else if (m_tmr > 0) begin
          m_tmr = m_tmr - 1;
          if (m_tmr == 0 && q.size() > 0) m_to = 1;
        end
      end else begin
        bit was;
        was = m_dr;
        if (rd_req) begin m_dr = 0; m_brk = 0; end
        if (rxin) begin
          if (was && !rd_req) m_ovr = 1;
          m_hold = b; m_dr = 1;
          if (rx_break) m_brk = 1;
        end
      end
    end
  end

  task automatic chk(string f, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] at %0t: actual=0x%0h expected=0x%0h", ph, f, $time, act, exp);
    end
  endtask

  task automatic compare();
    int exp_head, lvl;
    bit exp_trig;
    exp_head = m_ctl[0] ? ((q.size() > 0) ? int'(q[0]) : 0) : int'(m_hold);
    case (m_ctl[7:6])
      2'b00: lvl = 1;
      2'b01: lvl = 4;
      2'b10: lvl = 8;
      default: lvl = 14;
    endcase
    exp_trig = m_ctl[0] ? (q.size() >= lvl) : m_dr;
    chk("R2 rx_count", int'(rx_count), q.size());
    chk("R2 rd_data", int'(rd_data), exp_head);
    chk("R6 data_ready", int'(data_ready), int'(m_dr));
    chk("R8 break_flag", int'(break_flag), int'(m_brk));
    chk("R10 overrun_flag", int'(overrun_flag), int'(m_ovr));
    chk("R3 trig_hit", int'(trig_hit), int'(exp_trig));
    chk("R5 timeout_flag", int'(timeout_flag), int'(m_to));
    chk("R4 ctl_state", int'(ctl_state), int'(m_ctl));
    chk("R4 tx_flush", int'(tx_flush), int'(m_tx));
  endtask

  // one clock: compare away from the edge, then drive the next inputs
  task automatic cyc(bit rv, bit [7:0] d, bit br, bit rr, bit cw, bit [7:0] wd);
    @(negedge clk);
    compare();
    rx_valid = rv; rx_data = d; rx_break = br; rd_req = rr;
    ctl_wr = cw; ctl_wdata = wd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask
  task automatic rx(bit [7:0] d);  cyc(1, d, 0, 0, 0, 0); endtask
  task automatic rd();             cyc(0, 0, 0, 1, 0, 0); endtask
  task automatic brk();            cyc(0, 0, 1, 0, 0, 0); endtask
  task automatic wr(bit [7:0] v);  cyc(0, 0, 0, 0, 1, v); endtask

  initial begin
    rst_n = 1'b0; char_ticks = 12'd3;
    rx_valid = 0; rx_data = 0; rx_break = 0; rd_req = 0; ctl_wr = 0; ctl_wdata = 0;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    ph = "R7 holding";
    rx(8'hA5); idle(1); rd(); idle(1);
    rx(8'h11); rx(8'h22); idle(1); rd(); idle(1);
    ph = "R8 break holding";
    brk(); idle(1); rd(); idle(1);

    ph = "R4 enable";
    wr(8'h01); idle(2); wr(8'h01); idle(1);

    ph = "R2 fill and R10 full";
    for (int i = 0; i < 16; i++) rx(8'(i * 3 + 1));
    rx(8'hEE); idle(1);
    cyc(1, 8'hEF, 0, 1, 0, 0); idle(1);
    ph = "R9 drain and empty read";
    for (int i = 0; i < 17; i++) rd();
    idle(2);

    ph = "R2 wrap";
    for (int i = 0; i < 5; i++) rx(8'(8'h40 + i));
    for (int i = 0; i < 3; i++) rd();
    for (int i = 0; i < 8; i++) rx(8'(8'h60 + i));
    for (int i = 0; i < 10; i++) rd();
    idle(1);

    ph = "R3 trigger sweep";
    for (int s = 0; s < 4; s++) begin
      wr({2'(s), 6'b000001}); idle(1);
      for (int i = 0; i < 15; i++) rx(8'(8'h80 + i));
      idle(1);
      wr({2'(s), 6'b000011}); idle(1);
    end

    ph = "R5 timeout";
    wr(8'h01); idle(1);
    rx(8'h01); rx(8'h02); rx(8'h03);
    idle(14); rd(); idle(14); rd(); idle(5); rd(); rd();
    idle(15);
    rx(8'h09); idle(8); wr(8'h03); idle(14);
    rx(8'h0A); idle(11); rd(); idle(14);

    ph = "R12 receive with read";
    rx(8'h21); rx(8'h22);
    for (int i = 0; i < 5; i++) cyc(1, 8'(8'h30 + i), 0, 1, 0, 0);
    rd(); rd(); rd(); idle(1);

    ph = "R11 control priority";
    rx(8'h55); idle(1);
    cyc(1, 8'h66, 0, 1, 1, ctl_state); idle(1);
    rd(); idle(1);

    ph = "R4 tx flush";
    wr(8'h05); idle(2); wr(8'h0D); idle(1); wr(8'hC9); idle(1);

    ph = "R8 break queued";
    rx(8'h77); brk(); idle(1); rd(); rd(); idle(1);

    ph = "R4 disable";
    rx(8'h12); rx(8'h13); wr(8'h00); idle(1);
    ph = "R7 holding again";
    rx(8'h33); rd(); idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule